// File: doc/BRIEF.md
# Bit-Plane Character Class Marker Generator

This block takes one block of text held as eight bit planes and marks, for every byte position, which character classes the byte belongs to. Plane 0 carries the most significant bit of each byte and plane 7 the least significant. Position i of every plane and every output vector refers to the same byte. The block builds the classes with a small network of bitwise AND, OR and AND-NOT terms, and the classes share those terms. It has no per-byte comparators.

Six marker vectors are produced: the less-than sign, the greater-than sign, decimal digits, control codes, the semicolon, and a two-byte marker that flags a '#' directly preceded by '&'. That '&' may be the last position of the previous block. A partial block is described by a count of valid low positions, and every marker above that count is cleared. All results are registered, so they appear one cycle after the input strobe.

Top module: `byte_class_marker`

## Requirements
- R1: `out_lt` bit i is 1 exactly when byte i is 0x3C and i is below the valid count.
- R2: `out_gt` bit i is 1 exactly when byte i is 0x3E and i is below the valid count.
- R3: `out_digit` bit i is 1 exactly when byte i lies in 0x30..0x39 and i is below the valid count.
- R4: `out_ctrl` bit i is 1 exactly when byte i lies in 0x00..0x1F and i is below the valid count.
- R5: `out_semi` bit i is 1 exactly when byte i is 0x3B and i is below the valid count.
- R6: `out_pair` bit i (i greater than 0) is 1 exactly when byte i is 0x23, byte i-1 is 0x26, and i is below the valid count.
- R7: `out_pair` bit 0 is 1 only when byte 0 is 0x23 and the previous accepted block had count 128 or more and held 0x26 at position 127. Any other previous block leaves bit 0 at 0.
- R8: When `in_count` is c, positions c and above read 0 in every output. A value of 128 or more means a full block, and 0 means an empty block.
- R9: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, all marker outputs keep their values.
- R10: Reset drives `out_valid` and all marker outputs to 0 and clears the cross-block '&' memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Block strobe |
| in_count | input | 8 | Number of valid low positions |
| in_planes | input | 8x128 | Bit planes; plane 0 holds byte MSBs |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_lt | output | 128 | '<' markers |
| out_gt | output | 128 | '>' markers |
| out_digit | output | 128 | Digit markers |
| out_ctrl | output | 128 | Control-code markers |
| out_semi | output | 128 | ';' markers |
| out_pair | output | 128 | "&#" markers at the '#' position |

## Verification
Two full blocks together carry every byte value from 0x00 to 0xFF, one value per position. This sweep pins each class to its exact range and exposes any term that catches a neighbouring code. Pseudo-random blocks drawn from a small alphabet of '&', '#', '<', '>', ';' and digits, sent with assorted counts (0, 1, 64, 127, 128 and others), separate the in-block pair logic from the partial-block mask. Dedicated block pairs cover the cross-block '&': one with '&' at the last position of a full block, one where that position is beyond the count, and one separated by a reset. These show whether the carry is taken, masked and cleared.

// File: rtl/bclass_pkg.sv
package bclass_pkg;
  // Index of each class inside the shared class bundle
  typedef enum int {
    CL_LT    = 0,
    CL_GT    = 1,
    CL_DIGIT = 2,
    CL_CTRL  = 3,
    CL_SEMI  = 4
  } class_idx_e;

  localparam int NUM_SINGLE = 5;
  localparam int NUM_PLANES = 8;
endpackage

// File: rtl/bclass_terms.sv
module bclass_terms
  import bclass_pkg::*;
#(
  parameter int LANES = 128
) (
  input  logic [NUM_PLANES-1:0][LANES-1:0] planes,
  output logic [NUM_SINGLE-1:0][LANES-1:0] single,
  output logic [LANES-1:0]                 amp,
  output logic [LANES-1:0]                 hash
);
  logic [LANES-1:0] b0, b1, b2, b3, b4, b5, b6, b7;
  logic [LANES-1:0] hi_or01, hi_and23, hi_is3, lo_and45, lo_or67;
  logic [LANES-1:0] lo_is_c, lo_6n7, lo_is_e, hi_is2, lo_bits_11;

  assign b0 = planes[0];
  assign b1 = planes[1];
  assign b2 = planes[2];
  assign b3 = planes[3];
  assign b4 = planes[4];
  assign b5 = planes[5];
  assign b6 = planes[6];
  assign b7 = planes[7];

  // Shared terms
  assign hi_or01  = b0 | b1;
  assign hi_and23 = b2 & b3;
  assign hi_is3   = hi_and23 & ~hi_or01;           // upper nibble 0x3
  assign hi_is2   = b2 & ~b3 & ~hi_or01;           // upper nibble 0x2
  assign lo_and45 = b4 & b5;
  assign lo_or67  = b6 | b7;
  assign lo_is_c  = lo_and45 & ~lo_or67;           // lower nibble 0xC
  assign lo_6n7   = b6 & ~b7;
  assign lo_is_e  = lo_and45 & lo_6n7;             // lower nibble 0xE
  assign lo_bits_11 = b6 & b7;

  always_comb begin
    single           = '0;
    single[CL_LT]    = hi_is3 & lo_is_c;
    single[CL_GT]    = hi_is3 & lo_is_e;
    single[CL_CTRL]  = ~(hi_or01 | b2);
    single[CL_DIGIT] = hi_is3 & ~(b4 & (b5 | b6));
    single[CL_SEMI]  = hi_is3 & b4 & ~b5 & lo_bits_11;
  end

  assign amp  = hi_is2 & ~b4 & b5 & lo_6n7;        // 0x26
  assign hash = hi_is2 & ~b4 & ~b5 & lo_bits_11;   // 0x23
endmodule

// File: rtl/bclass_pair.sv
module bclass_pair #(
  parameter int LANES = 128
) (
  input  logic [LANES-1:0] amp,
  input  logic [LANES-1:0] hash,
  input  logic             carry_in,
  output logic [LANES-1:0] pair
);
  logic [LANES-1:0] amp_shifted;

  // Move each '&' one position up; the vacated bit 0 takes the carry
  assign amp_shifted = {amp[LANES-2:0], carry_in};
  assign pair        = hash & amp_shifted;
endmodule

// File: rtl/bclass_mask.sv
module bclass_mask #(
  parameter int LANES = 128,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [LANES-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = (count > CNT_W'(g));
  end
endmodule

// File: rtl/byte_class_marker.sv
module byte_class_marker
  import bclass_pkg::*;
#(
  parameter int LANES = 128,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [CNT_W-1:0]                 in_count,
  input  logic [NUM_PLANES-1:0][LANES-1:0] in_planes,
  output logic                             out_valid,
  output logic [LANES-1:0]                 out_lt,
  output logic [LANES-1:0]                 out_gt,
  output logic [LANES-1:0]                 out_digit,
  output logic [LANES-1:0]                 out_ctrl,
  output logic [LANES-1:0]                 out_semi,
  output logic [LANES-1:0]                 out_pair
);
  logic [NUM_SINGLE-1:0][LANES-1:0] single_raw, single_q, single_d;
  logic [LANES-1:0] amp, hash, pair_raw, pair_q, pair_d, mask;
  logic carry_q, carry_d, valid_q, valid_d;

  bclass_terms #(.LANES(LANES)) u_terms (
    .planes(in_planes), .single(single_raw), .amp(amp), .hash(hash)
  );

  bclass_pair #(.LANES(LANES)) u_pair (
    .amp(amp), .hash(hash), .carry_in(carry_q), .pair(pair_raw)
  );

  bclass_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
    .count(in_count), .mask(mask)
  );

  // Next state
  always_comb begin
    valid_d  = in_valid;
    single_d = single_q;
    pair_d   = pair_q;
    carry_d  = carry_q;
    if (in_valid) begin
      for (int c = 0; c < NUM_SINGLE; c++) single_d[c] = single_raw[c] & mask;
      pair_d  = pair_raw & mask;
      carry_d = amp[LANES-1] & mask[LANES-1];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      single_q <= '0;
      pair_q   <= '0;
      carry_q  <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      single_q <= single_d;
      pair_q   <= pair_d;
      carry_q  <= carry_d;
    end
  end

  assign out_valid = valid_q;
  assign out_lt    = single_q[CL_LT];
  assign out_gt    = single_q[CL_GT];
  assign out_digit = single_q[CL_DIGIT];
  assign out_ctrl  = single_q[CL_CTRL];
  assign out_semi  = single_q[CL_SEMI];
  assign out_pair  = pair_q;

  // Checks
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_lt) && $stable(out_digit) && $stable(out_pair))); // R9
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_lt & out_gt) | (out_digit & out_ctrl) | (out_semi & out_pair) | (out_lt & out_digit)) == '0); // R1
  AST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_lt | out_gt | out_digit | out_ctrl | out_semi | out_pair) & ~$past(mask)) == '0); // R8
  AST_CARRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !carry_q) |=> !out_pair[0]); // R7
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!out_valid && out_pair == '0); // R10
  end
endmodule

// File: tb/test_byte_class_marker.sv
module test_byte_class_marker;
  localparam int LANES = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [7:0] in_count;
  logic [7:0][LANES-1:0] in_planes;
  logic out_valid;
  logic [LANES-1:0] out_lt, out_gt, out_digit, out_ctrl, out_semi, out_pair;

  byte_class_marker i_byte_class_marker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
    .in_planes(in_planes), .out_valid(out_valid), .out_lt(out_lt), .out_gt(out_gt),
    .out_digit(out_digit), .out_ctrl(out_ctrl), .out_semi(out_semi), .out_pair(out_pair)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] bytes_a [LANES];
  logic bench_carry;
  logic [LANES-1:0] e_lt, e_gt, e_dig, e_ctl, e_semi, e_pair;
  logic [15:0] lfsr = 16'hACE1;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 100000", cycles);
      summary();
    end
  end

  task automatic chk(string tag, logic [LANES-1:0] got, logic [LANES-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compute(int cnt);
    for (int i = 0; i < LANES; i++) begin
      logic [7:0] b;
      logic ok, prev_amp;
      b = bytes_a[i];
      ok = (i < cnt);
      prev_amp = (i == 0) ? bench_carry : (bytes_a[i-1] == 8'h26);
      e_lt[i]   = ok && (b == 8'h3C);
      e_gt[i]   = ok && (b == 8'h3E);
      e_dig[i]  = ok && (b >= 8'h30) && (b <= 8'h39);
      e_ctl[i]  = ok && (b < 8'h20);
      e_semi[i] = ok && (b == 8'h3B);
      e_pair[i] = ok && (b == 8'h23) && prev_amp;
    end
    bench_carry = (cnt >= LANES) && (bytes_a[LANES-1] == 8'h26);
  endtask

  task automatic send(int cnt, string tag);
    @(negedge clk);
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < LANES; i++)
        in_planes[k][i] = bytes_a[i][7-k];
    in_count = 8'(cnt);
    in_valid = 1'b1;
    compute(cnt);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {127'b0, out_valid}, {127'b0, 1'b1});
    chk({tag, " R1 lt"}, out_lt, e_lt);
    chk({tag, " R2 gt"}, out_gt, e_gt);
    chk({tag, " R3 digit"}, out_digit, e_dig);
    chk({tag, " R4 ctrl"}, out_ctrl, e_ctl);
    chk({tag, " R5 semi"}, out_semi, e_semi);
    chk({tag, " R6 R7 R8 pair"}, out_pair, e_pair);
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] alpha [8];
    alpha = '{8'h26, 8'h23, 8'h3C, 8'h3E, 8'h3B, 8'h30, 8'h39, 8'h41};
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return alpha[lfsr[2:0]];
  endfunction

  initial begin
    int counts [10];
    counts = '{128, 0, 1, 64, 127, 128, 37, 100, 128, 2};
    rst_n = 1'b0; in_valid = 1'b0; in_count = '0; in_planes = '0;
    bench_carry = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset valid", {127'b0, out_valid}, '0);
    chk("R10 reset markers", out_lt | out_gt | out_digit | out_ctrl | out_semi | out_pair, '0);
    rst_n = 1'b1;

    // Exhaustive byte sweep over two blocks
    for (int blk = 0; blk < 2; blk++) begin
      for (int i = 0; i < LANES; i++) bytes_a[i] = 8'(blk * LANES + i);
      send(LANES, "sweep");
    end

    // R9 hold while idle
    for (int i = 0; i < LANES; i++) bytes_a[i] = 8'h3C;
    @(negedge clk);
    for (int k = 0; k < 8; k++) in_planes[k] = {LANES{k[0]}};
    @(negedge clk);
    chk("R9 idle valid low", {127'b0, out_valid}, '0);
    chk("R9 hold lt", out_lt, e_lt);
    chk("R9 hold ctrl", out_ctrl, e_ctl);

    // Random alphabet blocks with varied counts (R6 R8)
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < LANES; i++) bytes_a[i] = pick();
      send(counts[r % 10], "random");
    end

    // R7 carry taken across full block
    for (int i = 0; i < LANES; i++) bytes_a[i] = 8'h41;
    bytes_a[LANES-1] = 8'h26;
    send(LANES, "R7 setup");
    bytes_a[LANES-1] = 8'h41; bytes_a[0] = 8'h23;
    send(LANES, "R7 carry");
    chk("R7 carry bit0", {127'b0, out_pair[0]}, {127'b0, 1'b1});

    // R7 carry blocked by partial count
    bytes_a[0] = 8'h41; bytes_a[LANES-1] = 8'h26;
    send(100, "R7 masked setup");
    bytes_a[0] = 8'h23; bytes_a[LANES-1] = 8'h41;
    send(LANES, "R7 masked");
    chk("R7 masked bit0", {127'b0, out_pair[0]}, '0);

    // R10 reset clears carry
    bytes_a[0] = 8'h41; bytes_a[LANES-1] = 8'h26;
    send(LANES, "R10 setup");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bench_carry = 1'b0;
    bytes_a[0] = 8'h23; bytes_a[LANES-1] = 8'h41;
    send(LANES, "R10 after reset");
    chk("R10 carry cleared", {127'b0, out_pair[0]}, '0);

    summary();
  end
endmodule